// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block is the register front end that one peer of a shared-memory device uses to exchange interrupts with other peers. It holds four 32-bit registers:

- an interrupt mask;
- an interrupt status;
- a read-only peer position that reports this peer's assigned ID;
- a doorbell.

Writing the doorbell sends a request to another peer. The request carries a destination ID and a vector number.

Inbound doorbell events come from the routing fabric outside the block. A mode input decides how they are handled:

- **Pin mode.** Any inbound event sets the status register. A level interrupt is raised while mask bit 0 and the status bit are both set.
- **Message mode.** The inbound vector selects one of `NUM_VEC` message interrupt lines, which pulses for a single cycle. The status register is not touched. Vectors outside the configured range are discarded.

The peer position reads as all ones until the `ready` input reports that the shared region is usable. Outbound doorbell writes are also held back until then.

Top module: `db_peer_regs`

## Requirements
- R1: After reset the mask and status read as zero, `irq_pin` is low, `send_valid` is low and `msi_pulse` is all zeros.
- R2: Registers are selected by `bus_addr[3:2]`: 0 mask, 1 status, 2 peer position, 3 doorbell. `bus_addr[1:0]` is ignored. The mask stores and returns all 32 bits. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: With `ready` low a read of the peer position returns 0xFFFFFFFF. With `ready` high it returns `peer_id` zero-extended. Writes to it have no effect.
- R4: A doorbell write while `ready` is high asserts `send_valid` for exactly the next cycle. In that cycle `send_dest` equals `wdata[31:16]` and `send_vec` equals `wdata[15:0]`. Reads of the doorbell return zero.
- R5: A doorbell write while `ready` is low produces no `send_valid`.
- R6: In pin mode (`msg_mode`=0) an inbound event with any `rx_vec` sets status to 1 in the next cycle.
- R7: `irq_pin` is high exactly when mask bit 0 is 1 and status is 1. Mask bits 31:1 have no effect on it.
- R8: A read of the status returns its value and clears it to zero. If an inbound pin-mode event arrives in the same cycle as the read, the status ends at 1.
- R9: In message mode an inbound event with `rx_vec` < `NUM_VEC` drives `msi_pulse` one-hot at bit `rx_vec` for one cycle, starting one cycle after the event. The status is left unchanged.
- R10: In message mode an inbound event with `rx_vec` >= `NUM_VEC` produces no pulse and leaves the status unchanged.
- R11: A status write stores only `wdata[0]`. Status bits 31:1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_mode | input | 1 | 1 selects message interrupts, 0 selects pin interrupt |
| ready | input | 1 | Shared region usable; ID valid |
| peer_id | input | ID_W | Assigned ID of this peer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| send_valid | output | 1 | Outbound doorbell request |
| send_dest | output | 16 | Destination peer ID |
| send_vec | output | 16 | Vector for destination |
| rx_valid | input | 1 | Inbound doorbell event |
| rx_vec | input | 16 | Inbound vector |
| irq_pin | output | 1 | Level interrupt (pin mode) |
| msi_pulse | output | NUM_VEC | One-cycle message interrupt per vector |

## Verification
Inbound vectors are swept across every in-range value and several just past the limit in message mode. This separates a correct one-hot decode from an off-by-one range check. The same vectors are sent in pin mode to show that the vector value has no influence there.

Mask values with only upper bits set are tried against pending status to confirm that only bit 0 gates the level interrupt. A read that collides with an inbound event shows whether the clear or the set wins.

Doorbell words with distinct upper and lower halves reveal swapped or truncated fields. Several IDs are tried with `ready` toggled, showing the gating of both the position read and the send.

// File: rtl/db_peer_regs.sv
module db_peer_regs #(
  parameter int ID_W    = 16,
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_mode,
  input  logic               ready,
  input  logic [ID_W-1:0]    peer_id,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               send_valid,
  output logic [15:0]        send_dest,
  output logic [15:0]        send_vec,
  input  logic               rx_valid,
  input  logic [15:0]        rx_vec,
  output logic               irq_pin,
  output logic [NUM_VEC-1:0] msi_pulse
);
  localparam logic [1:0]  SEL_MASK = 2'd0;
  localparam logic [1:0]  SEL_STAT = 2'd1;
  localparam logic [1:0]  SEL_POS  = 2'd2;
  localparam logic [1:0]  SEL_BELL = 2'd3;
  localparam logic [16:0] VEC_LIM  = 17'(NUM_VEC);

  logic [31:0] mask_q;
  logic        stat_q;

  wire [1:0]  sel     = bus_addr[3:2];
  wire        wr_mask = bus_wr && sel == SEL_MASK;
  wire        wr_stat = bus_wr && sel == SEL_STAT;
  wire        wr_bell = bus_wr && sel == SEL_BELL && ready;
  wire        rd_stat = bus_rd && sel == SEL_STAT;
  wire        rx_pin  = rx_valid && !msg_mode;
  wire        rx_msg  = rx_valid && msg_mode && ({1'b0, rx_vec} < VEC_LIM);
  wire [31:0] pos_val = ready ? 32'(peer_id) : 32'hFFFF_FFFF;

  assign irq_pin = mask_q[0] & stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      if (rx_pin)       stat_q <= 1'b1;
      else if (wr_stat) stat_q <= bus_wdata[0];
      else if (rd_stat) stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_MASK: bus_rdata <= mask_q;
        SEL_STAT: bus_rdata <= {31'b0, stat_q};
        SEL_POS:  bus_rdata <= pos_val;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_valid <= 1'b0;
      send_dest  <= '0;
      send_vec   <= '0;
    end else begin
      send_valid <= wr_bell;
      if (wr_bell) begin
        send_dest <= bus_wdata[31:16];
        send_vec  <= bus_wdata[15:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_msi
    always_ff @(posedge clk) begin
      if (!rst_n) msi_pulse[i] <= 1'b0;
      else        msi_pulse[i] <= rx_msg && rx_vec == 16'(i);
    end
  end
endmodule

module db_peer_regs_chk #(
  parameter int NUM_VEC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_mode,
  input logic               ready,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [3:0]         bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               send_valid,
  input logic               rx_valid,
  input logic [15:0]        rx_vec,
  input logic               irq_pin,
  input logic [NUM_VEC-1:0] msi_pulse,
  input logic               stat_q
);
  localparam logic [16:0] LIM = 17'(NUM_VEC);

  wire touch_stat = (bus_wr || bus_rd) && bus_addr[3:2] == 2'd1;

  assert_msi_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msi_pulse));
  assert_msi_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|msi_pulse) |-> $past(rx_valid && msg_mode && ({1'b0, rx_vec} < LIM)));
  assert_send_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> $past(bus_wr && bus_addr[3:2] == 2'd3 && ready));
  assert_send_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd3 && !ready) |=> !send_valid);
  assert_pos_unready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] == 2'd2 && !ready) |=> bus_rdata == 32'hFFFF_FFFF);
  assert_pin_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !msg_mode) |=> stat_q);
  assert_msg_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && msg_mode && !touch_stat) |=> $stable(stat_q));
  assert_irq_needs_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin |-> stat_q);
endmodule

bind db_peer_regs db_peer_regs_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .ready(ready),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .send_valid(send_valid), .rx_valid(rx_valid), .rx_vec(rx_vec),
  .irq_pin(irq_pin), .msi_pulse(msi_pulse), .stat_q(stat_q)
);

// File: tb/sim_db_peer_regs.sv
module sim_db_peer_regs;
  localparam int NV = 4;

  logic clk = 0, rst_n = 0, msg_mode = 0, ready = 0;
  logic [15:0] peer_id = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic send_valid;
  logic [15:0] send_dest, send_vec;
  logic rx_valid = 0;
  logic [15:0] rx_vec = '0;
  logic irq_pin;
  logic [NV-1:0] msi_pulse;

  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  db_peer_regs #(.ID_W(16), .NUM_VEC(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .ready(ready), .peer_id(peer_id),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .send_valid(send_valid), .send_dest(send_dest),
    .send_vec(send_vec), .rx_valid(rx_valid), .rx_vec(rx_vec), .irq_pin(irq_pin),
    .msi_pulse(msi_pulse));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); #1 d = bus_rdata; bus_rd = 0;
  endtask

  task automatic rx(input logic [15:0] v);
    @(negedge clk); rx_valid = 1; rx_vec = v;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk); @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] masks [6];
    logic [15:0] ids [5];
    masks = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h8000_0001};
    ids   = '{16'h0, 16'h1, 16'h7, 16'hABCD, 16'hFFFF};

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 irq", 32'(irq_pin), 0);
    chk("R1 send_valid", 32'(send_valid), 0);
    chk("R1 msi", 32'(msi_pulse), 0);
    rd(4'h0, d); chk("R1 mask", d, 0);
    rd(4'h4, d); chk("R1 status", d, 0);

    peer_id = 16'h0005;
    rd(4'h8, d); chk("R3 pos unready", d, 32'hFFFF_FFFF);
    ready = 1;
    foreach (ids[i]) begin
      peer_id = ids[i];
      rd(4'h8, d); chk("R3 pos ready", d, {16'h0, ids[i]});
    end
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, d); chk("R3 pos write ignored", d, {16'h0, ids[4]});

    foreach (masks[i]) begin
      wr(4'h0, masks[i] ^ 32'h5A00_0000);
      rd(4'h3, d); chk("R2 mask alias", d, masks[i] ^ 32'h5A00_0000);
    end

    for (int k = 0; k < 12; k++) begin
      logic [31:0] w;
      w = {16'(k * 16'h1357 + 3), 16'(k * 16'h2468 + 1)};
      wr(4'hC, w);
      chk("R4 send_valid", 32'(send_valid), 1);
      chk("R4 dest", 32'(send_dest), 32'(w[31:16]));
      chk("R4 vec", 32'(send_vec), 32'(w[15:0]));
      idle();
      chk("R4 single cycle", 32'(send_valid), 0);
    end
    rd(4'hC, d); chk("R4 doorbell reads zero", d, 0);

    ready = 0;
    wr(4'hC, 32'h0003_0001);
    chk("R5 no send unready", 32'(send_valid), 0);
    ready = 1;

    msg_mode = 0;
    wr(4'h0, 32'h1);
    for (int v = 0; v < 8; v++) begin
      rx(16'(v * 16'h2345));
      chk("R6 irq after pin event", 32'(irq_pin), 1);
      rd(4'h4, d); chk("R8 status read", d, 1);
      chk("R8 cleared irq", 32'(irq_pin), 0);
      rd(4'h4, d); chk("R8 status cleared", d, 0);
    end

    foreach (masks[i]) begin
      wr(4'h0, masks[i]);
      rx(16'h00FF);
      chk("R7 irq vs mask", 32'(irq_pin), 32'(masks[i][0]));
      rd(4'h4, d); chk("R6 status set", d, 1);
    end

    wr(4'h0, 32'h1);
    @(negedge clk); rx_valid = 1; rx_vec = 0; bus_rd = 1; bus_addr = 4'h4;
    @(posedge clk); #1 d = bus_rdata; rx_valid = 0; bus_rd = 0;
    chk("R8 collision read old", d, 0);
    chk("R8 collision irq", 32'(irq_pin), 1);
    rd(4'h4, d); chk("R8 set wins", d, 1);

    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R11 status bit0 only", d, 1);
    wr(4'h4, 32'h0000_0002);
    rd(4'h4, d); chk("R11 status upper ignored", d, 0);

    msg_mode = 1;
    for (int v = 0; v < NV + 4; v++) begin
      rx(16'(v));
      chk(v < NV ? "R9 msi decode" : "R10 msi dropped", 32'(msi_pulse),
          v < NV ? 32'(1 << v) : 0);
      chk("R9 no irq in msg mode", 32'(irq_pin), 0);
      idle();
      chk("R9 pulse one cycle", 32'(msi_pulse), 0);
    end
    rx(16'hFFFF);
    chk("R10 max vector dropped", 32'(msi_pulse), 0);
    rd(4'h4, d); chk("R9 status untouched", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule